// File: doc/BRIEF.md
# Bidirectional On-the-Fly AES-128 Round-Key Walker

This block produces AES-128 round keys one at a time without keeping the whole expanded schedule. It holds a single 128-bit key register. That register can be moved one round forward, which is the order encryption uses, or one round back, which is the order decryption uses. The S-box word, the word-wise XOR chain and the round-constant state are shared between the two directions. Both directions therefore cost the logic of one step plus a small multiplexer.

**Loading a key.** Loading a cipher key starts a setup phase. During setup the block runs the forward schedule once, one round per clock, until the register holds the final round key. That final key is where decryption begins. When setup ends, `ready_o` rises.

**Stepping.** Once ready, the host gives one pulse on `step_i` for each round it needs. `dir_i` selects the direction: 1 walks back towards the cipher key for decryption, and 0 walks forward towards the last round key for encryption. The schedule has end points. The walker does nothing if asked to go past round 0 in one direction or past the last round in the other.

Top module: `aes_key_walker`

## Requirements
- R1: After reset `ready_o` is 0 and `rkey_o` is all zeros; `rkey_o` reads zero in every cycle in which `ready_o` is 0.
- R2: A load (`load_i`=1 at a clock edge) clears `ready_o` from the next cycle; `ready_o` rises exactly 10 clock edges after the load edge.
- R3: When `ready_o` rises, `rkey_o` holds round key 10 of the loaded key. The packing is word 0 in bits [127:96] and byte 0 of each word in its top byte, on both `key_i` and `rkey_o`.
- R4: A backward step (`step_i`=1 with `dir_i`=1) while ready replaces `rkey_o` with the previous round key from the next cycle on. The steps use round constants 0x36, 0x1B, ... 0x01, each derived from the last by division by x: shift right, then XOR 0x8D when bit 0 was set.
- R5: A forward step (`step_i`=1 with `dir_i`=0) while ready replaces `rkey_o` with the next round key from the next cycle on. It applies SubBytes to the last word rotated left by 8 bits, and the round constant sits in the top byte. The constant starts at 0x01 and is multiplied by x with reduction by 0x1B.
- R6: Step pulses given while `ready_o` is 0, during setup or before any load, have no effect on the key that appears once setup completes.
- R7: A backward step at round 0 and a forward step at round 10 leave `rkey_o` unchanged.
- R8: A load restarts setup with the new key at any time, also during setup, and takes priority over a step in the same cycle.
- R9: While ready, with no step and no load, `rkey_o` and `ready_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load `key_i` as the new cipher key and start setup |
| key_i | input | 128 | Cipher key |
| dir_i | input | 1 | Step direction: 0 forward, 1 backward |
| step_i | input | 1 | Move one round in direction `dir_i` |
| rkey_o | output | 128 | Current round key (zero while not ready) |
| ready_o | output | 1 | Setup finished, round key valid |

## Verification
The published 128-bit key expansion vector is walked all the way down from round 10 to round 0 and then back up. This separates a wrong backward constant sequence or word chain from a wrong forward one, because each direction is compared against the same eleven known keys.

An all-zero cipher key exercises the round-constant path with no other key material to hide it. Walking that key back to zero and one step forward checks that setup and reversal are exact inverses.

Step pulses during setup and before any key, loads issued in the middle of setup, and steps at both ends of the schedule separate the three conditions that must block an update from those that must not.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 32;
   localparam logic [7:0] RCON_SEED   = 8'h01;
   localparam logic [7:0] AFFINE_C    = 8'h63;
   localparam logic [7:0] XTIME_POLY  = 8'h1B;
   localparam logic [7:0] XDIV_POLY   = 8'h8D;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_BWD = 1'b1
   } walk_dir_e;

   // multiply by x modulo the field polynomial
   function automatic byte_t gf_xtime(input byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? XTIME_POLY : 8'h00);
   endfunction

   // divide by x: inverse of gf_xtime
   function automatic byte_t gf_xdiv(input byte_t a);
      return {1'b0, a[7:1]} ^ (a[0] ? XDIV_POLY : 8'h00);
   endfunction

   function automatic byte_t gf_mul(input byte_t a, input byte_t b);
      byte_t acc;
      byte_t m;
      acc = '0;
      m   = a;
      for (int i = 0; i < BYTE_W; i++) begin
         if (b[i]) acc = acc ^ m;
         m = gf_xtime(m);
      end
      return acc;
   endfunction

   // a^254 = a^-1 (zero maps to zero)
   function automatic byte_t gf_inv(input byte_t a);
      byte_t sq;
      byte_t prod;
      sq   = a;
      prod = 8'h01;
      for (int k = 1; k < BYTE_W; k++) begin
         sq   = gf_mul(sq, sq);
         prod = gf_mul(prod, sq);
      end
      return prod;
   endfunction

   function automatic byte_t sbox_affine(input byte_t b);
      byte_t o;
      for (int i = 0; i < BYTE_W; i++) begin
         o[i] = b[i] ^ b[(i + 4) % 8] ^ b[(i + 5) % 8] ^
                b[(i + 6) % 8] ^ b[(i + 7) % 8] ^ AFFINE_C[i];
      end
      return o;
   endfunction

   function automatic byte_t sbox_calc(input byte_t a);
      return sbox_affine(gf_inv(a));
   endfunction

   function automatic logic [2047:0] build_sbox_lut();
      logic [2047:0] t;
      t = '0;
      for (int v = 0; v < 256; v++) begin
         t[v*8 +: 8] = sbox_calc(byte_t'(v));
      end
      return t;
   endfunction

   function automatic word_t rot_word(input word_t w);
      return {w[23:0], w[31:24]};
   endfunction

endpackage

// File: rtl/aes_ks_sbox_byte.sv
module aes_ks_sbox_byte
   import aes_ks_pkg::*;
#(
   parameter int SBOX_STYLE = 0
) (
   input  logic [7:0] byte_i,
   output logic [7:0] byte_o
);

   generate
      if (SBOX_STYLE == 0) begin : g_calc
         // inversion by square-and-multiply chain, then affine map
         assign byte_o = sbox_calc(byte_i);
      end else begin : g_lut
         localparam logic [2047:0] LUT = build_sbox_lut();
         assign byte_o = LUT[{byte_i, 3'b000} +: 8];
      end
   endgenerate

endmodule

// File: rtl/aes_ks_subword.sv
module aes_ks_subword
   import aes_ks_pkg::*;
#(
   parameter int SBOX_STYLE = 0
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);

   localparam int LANES = WORD_W / BYTE_W;

   generate
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         aes_ks_sbox_byte #(
            .SBOX_STYLE(SBOX_STYLE)
         ) u_sbox (
            .byte_i(word_i[b*BYTE_W +: BYTE_W]),
            .byte_o(word_o[b*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/aes_ks_rcon.sv
module aes_ks_rcon
   import aes_ks_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_i,
   input  logic       fwd_i,
   input  logic       bwd_i,
   output logic [7:0] rc_fwd_o,
   output logic [7:0] rc_bwd_o
);

   // rc_q = x^idx: the constant a forward step from round idx uses.
   // A backward step from idx uses x^(idx-1), which is also the new state.
   byte_t rc_q;
   byte_t rc_d;

   assign rc_fwd_o = rc_q;
   assign rc_bwd_o = gf_xdiv(rc_q);

   always_comb begin
      rc_d = rc_q;
      if (init_i)     rc_d = RCON_SEED;
      else if (fwd_i) rc_d = gf_xtime(rc_q);
      else if (bwd_i) rc_d = rc_bwd_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rc_q <= RCON_SEED;
      else        rc_q <= rc_d;
   end

endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step
   import aes_ks_pkg::*;
#(
   parameter int KEY_W      = 128,
   parameter int SBOX_STYLE = 0
) (
   input  logic [KEY_W-1:0] key_i,
   input  logic             bwd_i,
   input  logic [7:0]       rc_fwd_i,
   input  logic [7:0]       rc_bwd_i,
   output logic [KEY_W-1:0] key_o
);

   localparam int NW = KEY_W / WORD_W;

   word_t w  [NW];
   word_t fw [NW];
   word_t bw [NW];
   word_t sb_in;
   word_t sb_out;
   word_t tweak;
   byte_t rc_sel;

   generate
      for (genvar j = 0; j < NW; j++) begin : g_unpack
         assign w[j] = key_i[KEY_W-1-WORD_W*j -: WORD_W];
      end
      for (genvar j = 1; j < NW; j++) begin : g_bchain
         assign bw[j] = w[j] ^ w[j-1];
      end
   endgenerate

   // one shared S-box word: forward reads the last word, backward the
   // reconstructed last word of the previous round
   assign sb_in  = bwd_i ? bw[NW-1] : w[NW-1];
   assign rc_sel = bwd_i ? rc_bwd_i : rc_fwd_i;

   aes_ks_subword #(
      .SBOX_STYLE(SBOX_STYLE)
   ) u_subword (
      .word_i(rot_word(sb_in)),
      .word_o(sb_out)
   );

   assign tweak = sb_out ^ {rc_sel, {(WORD_W-BYTE_W){1'b0}}};
   assign bw[0] = w[0] ^ tweak;

   always_comb begin
      fw[0] = w[0] ^ tweak;
      for (int j = 1; j < NW; j++) begin
         fw[j] = w[j] ^ fw[j-1];
      end
   end

   generate
      for (genvar j = 0; j < NW; j++) begin : g_pack
         assign key_o[KEY_W-1-WORD_W*j -: WORD_W] = bwd_i ? bw[j] : fw[j];
      end
   endgenerate

endmodule

// File: rtl/aes_ks_ctrl.sv
module aes_ks_ctrl
   import aes_ks_pkg::*;
#(
   parameter int ROUNDS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic step_i,
   input  logic dir_i,
   output logic ready_o,
   output logic adv_fwd_o,
   output logic adv_bwd_o
);

   localparam int IDX_W = $clog2(ROUNDS + 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROUNDS);
   localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(ROUNDS - 1);

   typedef enum logic [1:0] {
      CS_EMPTY = 2'd0,
      CS_SETUP = 2'd1,
      CS_READY = 2'd2
   } ctrl_state_e;

   ctrl_state_e      st_q;
   logic [IDX_W-1:0] idx_q;

   assign ready_o = (st_q == CS_READY);

   always_comb begin
      adv_fwd_o = 1'b0;
      adv_bwd_o = 1'b0;
      if (!load_i) begin
         unique case (st_q)
            CS_SETUP: adv_fwd_o = 1'b1;
            CS_READY: begin
               if (step_i) begin
                  if (walk_dir_e'(dir_i) == DIR_FWD) adv_fwd_o = (idx_q != IDX_LAST);
                  else                               adv_bwd_o = (idx_q != '0);
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= CS_EMPTY;
         idx_q <= '0;
      end else if (load_i) begin
         st_q  <= CS_SETUP;
         idx_q <= '0;
      end else begin
         if (st_q == CS_SETUP && idx_q == IDX_PRE) st_q <= CS_READY;
         if (adv_fwd_o)      idx_q <= idx_q + 1'b1;
         else if (adv_bwd_o) idx_q <= idx_q - 1'b1;
      end
   end

endmodule

// File: rtl/aes_key_walker.sv
module aes_key_walker
   import aes_ks_pkg::*;
#(
   parameter int KEY_W      = 128,
   parameter int ROUNDS     = 10,
   parameter int SBOX_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [KEY_W-1:0]  key_i,
   input  logic              dir_i,
   input  logic              step_i,
   output logic [KEY_W-1:0]  rkey_o,
   output logic              ready_o
);

   generate
      if (KEY_W != 128) begin : g_bad_key_w
         $error("aes_key_walker: KEY_W must be 128");
      end
      if (ROUNDS < 1 || ROUNDS > 14) begin : g_bad_rounds
         $error("aes_key_walker: ROUNDS out of range 1..14");
      end
      if (SBOX_STYLE != 0 && SBOX_STYLE != 1) begin : g_bad_sbox
         $error("aes_key_walker: SBOX_STYLE must be 0 or 1");
      end
   endgenerate

   logic             adv_fwd;
   logic             adv_bwd;
   logic             ready;
   logic [7:0]       rc_fwd;
   logic [7:0]       rc_bwd;
   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] key_nx;

   aes_ks_ctrl #(
      .ROUNDS(ROUNDS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .step_i   (step_i),
      .dir_i    (dir_i),
      .ready_o  (ready),
      .adv_fwd_o(adv_fwd),
      .adv_bwd_o(adv_bwd)
   );

   aes_ks_rcon u_rcon (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (load_i),
      .fwd_i   (adv_fwd),
      .bwd_i   (adv_bwd),
      .rc_fwd_o(rc_fwd),
      .rc_bwd_o(rc_bwd)
   );

   aes_ks_step #(
      .KEY_W     (KEY_W),
      .SBOX_STYLE(SBOX_STYLE)
   ) u_step (
      .key_i   (key_q),
      .bwd_i   (adv_bwd),
      .rc_fwd_i(rc_fwd),
      .rc_bwd_i(rc_bwd),
      .key_o   (key_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 key_q <= '0;
      else if (load_i)            key_q <= key_i;
      else if (adv_fwd | adv_bwd) key_q <= key_nx;
   end

   assign ready_o = ready;
   assign rkey_o  = ready ? key_q : '0;

endmodule

// File: rtl/aes_key_walker_chk.sv
module aes_key_walker_chk #(
   parameter int KEY_W  = 128,
   parameter int ROUNDS = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic             dir_i,
   input logic             step_i,
   input logic [KEY_W-1:0] rkey_o,
   input logic             ready_o
);

   localparam int CW = $clog2(ROUNDS + 2) + 1;
   localparam logic [CW-1:0] CNT_SAT  = CW'(ROUNDS + 1);
   localparam logic [CW-1:0] CNT_DONE = CW'(ROUNDS);
   localparam logic [CW-1:0] IDX_TOP  = CW'(ROUNDS);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] idx_m;

   // edges since the last load, saturating
   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_i)           cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
   end

   // round index as seen from the ports
   always_ff @(posedge clk) begin
      if (!rst_n)       idx_m <= '0;
      else if (load_i)  idx_m <= IDX_TOP;
      else if (ready_o && step_i) begin
         if (!dir_i && idx_m != IDX_TOP) idx_m <= idx_m + 1'b1;
         else if (dir_i && idx_m != '0)  idx_m <= idx_m - 1'b1;
      end
   end

   a_r1_blank_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> (rkey_o == '0));

   a_r2_load_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !ready_o);

   a_r2_setup_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> (cnt_q == CNT_DONE));

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !load_i && !step_i) |=> ($stable(rkey_o) && ready_o));

   a_r7_fwd_top_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && step_i && !load_i && !dir_i && idx_m == IDX_TOP) |=> $stable(rkey_o));

   a_r7_bwd_bottom_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && step_i && !load_i && dir_i && idx_m == '0) |=> $stable(rkey_o));

endmodule

bind aes_key_walker aes_key_walker_chk #(
   .KEY_W (KEY_W),
   .ROUNDS(ROUNDS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .load_i (load_i),
   .dir_i  (dir_i),
   .step_i (step_i),
   .rkey_o (rkey_o),
   .ready_o(ready_o)
);

// File: tb/aes_key_walker_bench.sv
module aes_key_walker_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NSTEP      = 23;

   // published expansion of key 2b7e1516...09cf4f3c, rounds 0..10
   localparam logic [127:0] RK [0:10] = '{
      128'h2b7e151628aed2a6abf7158809cf4f3c,
      128'ha0fafe1788542cb123a339392a6c7605,
      128'hf2c295f27a96b9435935807a7359f67f,
      128'h3d80477d4716fe3e1e237e446d7a883b,
      128'hef44a541a8525b7fb671253bdb0bad00,
      128'hd4d1c6f87c839d87caf2b8bc11f915bc,
      128'h6d88a37a110b3efddbf98641ca0093fd,
      128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
      128'head27321b58dbad2312bf5607f8d292f,
      128'hac7766f319fadc2128d12941575c006e,
      128'hd014f9a8c9ee2589e13f0cc8b6630ca6
   };

   // stimulus walk: direction (1 = backward) and round index expected after it
   localparam bit [0:NSTEP-1] WALK_DIR =
      23'b1111111111_1_0000000000_0_1;
   localparam int WALK_IDX [0:NSTEP-1] = '{
      9, 8, 7, 6, 5, 4, 3, 2, 1, 0,
      0,
      1, 2, 3, 4, 5, 6, 7, 8, 9, 10,
      10,
      9
   };

   logic         clk;
   logic         rst_n;
   logic         load;
   logic [127:0] key_in;
   logic         dir;
   logic         step;
   logic [127:0] rkey;
   logic         ready;

   int checks;
   int errors;
   bit done;

   aes_key_walker u_aes_key_walker (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .key_i  (key_in),
      .dir_i  (dir),
      .step_i (step),
      .rkey_o (rkey),
      .ready_o(ready)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [127:0] k);
      @(negedge clk);
      load   = 1'b1;
      key_in = k;
      @(negedge clk);
      load   = 1'b0;
   endtask

   task automatic do_step(input logic d);
      @(negedge clk);
      step = 1'b1;
      dir  = d;
      @(negedge clk);
      step = 1'b0;
   endtask

   // after do_load returns: 9 more edges keep ready low, the 10th raises it
   task automatic wait_setup(input string req);
      repeat (8) @(negedge clk);
      @(negedge clk);
      check(req, {127'd0, ready}, 128'd0);
      @(negedge clk);
      check(req, {127'd0, ready}, 128'd1);
   endtask

   initial begin
      checks = 0;
      errors = 0;
      done   = 1'b0;
      rst_n  = 1'b0;
      load   = 1'b0;
      key_in = '0;
      dir    = 1'b0;
      step   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 ready after reset", {127'd0, ready}, 128'd0);
      check("R1 rkey after reset", rkey, 128'd0);

      // R6: steps before any key do nothing
      do_step(1'b0);
      do_step(1'b1);
      check("R6 no key: ready", {127'd0, ready}, 128'd0);
      check("R6 no key: rkey", rkey, 128'd0);

      // R2/R3: setup on the published key
      do_load(RK[0]);
      check("R2 ready low after load", {127'd0, ready}, 128'd0);
      check("R1 rkey blank in setup", rkey, 128'd0);
      wait_setup("R2 setup length");
      check("R3 last round key", rkey, RK[10]);

      // R9: idle hold
      repeat (3) @(negedge clk);
      check("R9 idle hold", rkey, RK[10]);

      // R4/R5/R7: table walk down, past bottom, up, past top, one back
      for (int i = 0; i < NSTEP; i++) begin
         do_step(WALK_DIR[i]);
         if (i == 10 || i == 21)
            check("R7 end of schedule ignored", rkey, RK[WALK_IDX[i]]);
         else if (WALK_DIR[i])
            check("R4 backward step", rkey, RK[WALK_IDX[i]]);
         else
            check("R5 forward step", rkey, RK[WALK_IDX[i]]);
      end

      // R6: steps during setup are ignored
      do_load(RK[0]);
      step = 1'b1;
      dir  = 1'b1;
      repeat (8) @(negedge clk);
      step = 1'b0;
      @(negedge clk);
      check("R6 ready during setup", {127'd0, ready}, 128'd0);
      @(negedge clk);
      check("R6 steps in setup ignored", rkey, RK[10]);

      // R8: reload in the middle of setup restarts with the new key
      do_load(128'h0);
      repeat (4) @(negedge clk);
      do_load(RK[0]);
      wait_setup("R8 restart timing");
      check("R8 restarted key", rkey, RK[10]);

      // R8: load wins over a step in the same cycle
      @(negedge clk);
      load   = 1'b1;
      key_in = 128'h0;
      step   = 1'b1;
      dir    = 1'b1;
      @(negedge clk);
      load = 1'b0;
      step = 1'b0;
      check("R8 load beats step", {127'd0, ready}, 128'd0);
      wait_setup("R8 zero-key setup");

      // R4/R5: zero key walked back to round 0, then one forward
      for (int i = 0; i < 10; i++) do_step(1'b1);
      check("R4 zero key back to start", rkey, 128'h0);
      do_step(1'b0);
      check("R5 zero key round 1", rkey, 128'h62636363626363636263636362636363);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule